// File: doc/BRIEF.md
# Periodic Delay-Channel Sample Scheduler

This block holds a small bank of programmable delay channels that pace conversion requests for an analog front end. Every channel counts down a programmed number of timebase ticks. When that count runs out, it fires a one-clock start strobe toward each conversion slot named in its slot mask. It can also restart any delay channels named in its chain mask. A channel that names itself in its chain mask restarts on every expiry, which gives periodic sampling. A channel with a loop count instead repeats a fixed number of times and then stops by itself.

Software programs each channel through a 32-bit register. Each register has three write aliases: plain write, bitwise set and bitwise clear. A read port returns the live register contents. A free-running prescaler divides the system clock down to the timebase tick, nominally 2 kHz. With that tick, a delay of 200 gives a 100 ms period.

Top module: `delay_sched`

## Requirements
- R1: After reset, `slot_start` and `dch_kick` are zero and every channel register reads zero.
- R2: Channel n lives at byte address n*16, and reads at offsets 0, 4 and 8 return it one clock after the address is presented. Its fields are: delay in bits 10:0, loop count in bits 15:11, chain mask in bits 19:16, run (kick) bit in bit 20 and slot mask in bits 31:24. Bits 23:21 always read zero.
- R3: A write at offset 0 replaces the register, offset 4 ORs the data into it, and offset 8 clears the bits set in the data.
- R4: A running channel with delay D≥1 expires once every D ticks (D×TICK_DIV clocks). Each expiry raises `slot_start` for exactly one clock, equal to the channel's slot mask.
- R5: A channel started with loop count L and no self bit expires exactly L+1 times, then its run bit reads 0.
- R6: A channel whose chain mask contains its own index keeps expiring and its run bit stays 1. On each expiry `dch_kick` shows its chain mask.
- R7: On an expiry, `dch_kick` equals the channel's chain mask in the same clock as `slot_start`. Each named channel starts with its run bit set, and its first expiry follows D_target ticks later.
- R8: Clearing the run bit through the clear alias stops the channel. No further strobes appear, and the other fields keep their values.
- R9: Writing zero to a channel register disables it. No strobes appear and it reads zero.
- R10: A running channel with delay 0 expires on every tick (period TICK_DIV clocks).
- R11: Writes to offset 12, or to an address with nonzero bits 1:0, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write byte address (channel, alias) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Read byte address |
| reg_rdata | output | 32 | Register contents, one clock after reg_raddr |
| slot_start | output | 8 | Per-slot conversion start strobes |
| dch_kick | output | 4 | Per-channel chain kick strobes |

## Verification
A write takes effect at the clock edge on which it is presented. The strobes of an expiry appear one edge after the tick on which the counter reaches its end. Read data is due one edge after the read address. The bench drives and samples on the falling edge, so every result is read after its register has settled. The prescaler phase is free-running, so the time from a start write to the first expiry can vary. For that reason the bench checks periods and chain delays as exact strobe-to-strobe distances in clocks, and checks expiry counts over a fixed window.

// File: rtl/dsched_pkg.sv
package dsched_pkg;
  localparam int NUM_DCH  = 4;
  localparam int NUM_SLOT = 8;
  localparam int DLY_W    = 11;
  localparam int LOOP_W   = 5;
  localparam int REG_W    = 32;

  typedef struct packed {
    logic [NUM_SLOT-1:0] slots;  // 31:24
    logic [2:0]          rsvd;   // 23:21
    logic                kick;   // 20
    logic [NUM_DCH-1:0]  chain;  // 19:16
    logic [LOOP_W-1:0]   loops;  // 15:11
    logic [DLY_W-1:0]    delay;  // 10:0
  } dch_cfg_t;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } reg_op_e;
endpackage

// File: rtl/dsched_tick.sv
module dsched_tick #(
  parameter int TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)                pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_gap
      // R4
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dsched_decode.sv
module dsched_decode
  import dsched_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_DCH-1:0] sel,
  output reg_op_e           op
);
  localparam int CHW = ADDR_W - 4;

  logic [CHW-1:0] ch_idx;
  logic           valid;

  assign ch_idx = addr[ADDR_W-1:4];
  assign op     = reg_op_e'(addr[3:2]);
  assign valid  = wr_en && (addr[1:0] == 2'b00) && (op != OP_NONE);

  generate
    for (genvar i = 0; i < NUM_DCH; i++) begin : g_sel
      assign sel[i] = valid && (int'(ch_idx) == i);
    end
  endgenerate
endmodule

// File: rtl/dsched_chan.sv
module dsched_chan
  import dsched_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr,
  input  reg_op_e          op,
  input  logic [REG_W-1:0] wdata,
  input  logic             kick_in,
  output dch_cfg_t         cfg,
  output logic             expire
);
  dch_cfg_t          cfg_q, cfg_wr;
  logic [DLY_W-1:0]  cnt_q;
  logic [LOOP_W-1:0] left_q;

  always_comb begin
    case (op)
      OP_WRITE: cfg_wr = dch_cfg_t'(wdata);
      OP_SET:   cfg_wr = cfg_q | dch_cfg_t'(wdata);
      default:  cfg_wr = cfg_q & ~dch_cfg_t'(wdata);
    endcase
    cfg_wr.rsvd = '0;
  end

  assign expire = tick && cfg_q.kick && (cnt_q <= DLY_W'(1));
  assign cfg    = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      left_q <= '0;
    end else if (wr) begin
      cfg_q <= cfg_wr;
      if (cfg_wr.kick && !cfg_q.kick) begin
        cnt_q  <= cfg_wr.delay;
        left_q <= cfg_wr.loops;
      end
    end else if (kick_in) begin
      cfg_q.kick <= 1'b1;
      cnt_q      <= cfg_q.delay;
      left_q     <= cfg_q.loops;
    end else if (expire) begin
      cnt_q <= cfg_q.delay;
      if (left_q == '0) cfg_q.kick <= 1'b0;
      else              left_q     <= left_q - 1'b1;
    end else if (tick && cfg_q.kick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.kick && tick && cnt_q > DLY_W'(1) && !wr && !kick_in)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  loop_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cfg_q.kick) && !$past(wr))
      |-> ($past(expire) && ($past(left_q) == '0)));

  // R6
  self_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.kick && cfg_q.chain[IDX] && !wr) |=> cfg_q.kick);
endmodule

// File: rtl/delay_sched.sv
module delay_sched
  import dsched_pkg::*;
#(
  parameter int TICK_DIV = 125000,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_waddr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic [ADDR_W-1:0]   reg_raddr,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_SLOT-1:0] slot_start,
  output logic [NUM_DCH-1:0]  dch_kick
);
  localparam int CHW = ADDR_W - 4;

  logic                tick;
  logic [NUM_DCH-1:0]  wr_sel;
  reg_op_e             wr_op;
  dch_cfg_t            cfg [NUM_DCH];
  logic [NUM_DCH-1:0]  expire;
  logic [NUM_SLOT-1:0] slot_nx;
  logic [NUM_DCH-1:0]  kick_nx;
  logic [CHW-1:0]      rch;
  logic                rd_hit;

  dsched_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  dsched_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(reg_wr),
    .addr (reg_waddr),
    .sel  (wr_sel),
    .op   (wr_op)
  );

  generate
    for (genvar i = 0; i < NUM_DCH; i++) begin : g_ch
      dsched_chan #(.IDX(i)) u_ch (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .wr     (wr_sel[i]),
        .op     (wr_op),
        .wdata  (reg_wdata),
        .kick_in(kick_nx[i]),
        .cfg    (cfg[i]),
        .expire (expire[i])
      );

      // R7
      chain_reach_chk: assert property (@(posedge clk) disable iff (rst)
        dch_kick[i] |-> (cfg[i].kick || $past(wr_sel[i])));
    end
  endgenerate

  always_comb begin
    slot_nx = '0;
    kick_nx = '0;
    for (int i = 0; i < NUM_DCH; i++) begin
      if (expire[i]) begin
        slot_nx = slot_nx | cfg[i].slots;
        kick_nx = kick_nx | cfg[i].chain;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_start <= '0;
      dch_kick   <= '0;
    end else begin
      slot_start <= slot_nx;
      dch_kick   <= kick_nx;
    end
  end

  assign rch    = reg_raddr[ADDR_W-1:4];
  assign rd_hit = (reg_raddr[1:0] == 2'b00) && (reg_raddr[3:2] != 2'b11)
                  && (int'(rch) < NUM_DCH);

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (rd_hit) reg_rdata <= cfg[rch];
    else             reg_rdata <= '0;
  end

  // R4
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (|slot_start) |-> $past(tick));
endmodule

// File: tb/delay_sched_tb.sv
module delay_sched_tb;
  localparam int TDIV = 4;
  localparam int WIN  = 200;
  localparam int NV   = 6;

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] val;
    logic [7:0]  slots;
    logic [3:0]  kick;
    logic [7:0]  cnt;   // 0: periodic, expect at least 3
    logic [15:0] per;   // 0: no period check
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0110_0005, 8'h01, 4'h0, 8'd1, 16'd0,  8'd4},  // R4 single
    '{2'd1, 32'h8210_1003, 8'h82, 4'h0, 8'd3, 16'd12, 8'd5},  // R5 loop 2
    '{2'd2, 32'h1014_0002, 8'h10, 4'h4, 8'd0, 16'd8,  8'd6},  // R6 self
    '{2'd3, 32'h2010_1800, 8'h20, 4'h0, 8'd4, 16'd4,  8'd10}, // R10 delay 0
    '{2'd0, 32'hFF10_0807, 8'hFF, 4'h0, 8'd2, 16'd28, 8'd5},  // R5 loop 1
    '{2'd1, 32'h4010_0001, 8'h40, 4'h0, 8'd1, 16'd0,  8'd4}   // R4 delay 1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [5:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  slot_start;
  logic [3:0]  dch_kick;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  delay_sched #(.TICK_DIV(TDIV), .ADDR_W(6)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .slot_start(slot_start), .dch_kick(dch_kick)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic quiet(input int cycles, output int hits);
    hits = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (slot_start != 8'h00) hits++;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int hits, t0, t1;
    logic [3:0] k0;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(slot_start == 8'h00 && dch_kick == 4'h0, "R1 strobes",
        {slot_start, dch_kick}, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(6'(c * 16), r);
      chk(r == 32'h0, "R1 register", r, 32'h0);
    end

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int seen, first, second;
      bit patt_ok;
      logic [11:0] bad;
      t = VECS[v];
      seen = 0; first = -1; second = -1; patt_ok = 1'b1; bad = '0;
      wr({t.ch, 4'h0}, t.val);
      for (int c = 0; c < WIN; c++) begin
        @(negedge clk);
        if (slot_start != 8'h00) begin
          if (slot_start !== t.slots || dch_kick !== t.kick) begin
            patt_ok = 1'b0; bad = {slot_start, dch_kick};
          end
          if (seen == 0) first = c;
          else if (seen == 1) second = c;
          seen++;
        end
      end
      chk(patt_ok, $sformatf("R%0d strobe pattern v%0d", t.req, v),
          32'(bad), {20'h0, t.slots, t.kick});
      if (t.cnt != 0)
        chk(seen == int'(t.cnt), $sformatf("R%0d expiry count v%0d", t.req, v),
            seen, 32'(t.cnt));
      else
        chk(seen >= 3, $sformatf("R%0d periodic count v%0d", t.req, v), seen, 3);
      if (t.per != 0)
        chk(second - first == int'(t.per),
            $sformatf("R%0d period v%0d", t.req, v), second - first, 32'(t.per));
      if (t.cnt != 0) begin
        rd({t.ch, 4'h0}, r);
        chk(r[20] == 1'b0, $sformatf("R5 run bit self-cleared v%0d", v),
            r, t.val & ~32'h0010_0000);
      end
      wr({t.ch, 4'h0}, 32'h0);
    end

    // R2 field layout, reserved bits
    wr(6'h10, 32'hFFEF_FFFF);
    rd(6'h10, r);
    chk(r == 32'hFF0F_FFFF, "R2 layout", r, 32'hFF0F_FFFF);
    rd(6'h18, r);
    chk(r == 32'hFF0F_FFFF, "R2 alias read", r, 32'hFF0F_FFFF);

    // R3 set and clear aliases
    wr(6'h10, 32'h0000_0012);
    wr(6'h14, 32'h0100_0000);
    rd(6'h10, r);
    chk(r == 32'h0100_0012, "R3 set alias", r, 32'h0100_0012);
    wr(6'h18, 32'h0000_0002);
    rd(6'h10, r);
    chk(r == 32'h0100_0010, "R3 clear alias", r, 32'h0100_0010);

    // R11 ignored addresses
    wr(6'h1C, 32'h0000_FFFF);
    wr(6'h11, 32'h0000_0000);
    rd(6'h10, r);
    chk(r == 32'h0100_0010, "R11 ignored writes", r, 32'h0100_0010);
    wr(6'h10, 32'h0);

    // R7 chaining ch0 -> ch1
    wr(6'h10, 32'h0200_0003);
    wr(6'h00, 32'h0112_0002);
    t0 = -1; t1 = -1; k0 = '0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (slot_start == 8'h01 && t0 < 0) begin t0 = c; k0 = dch_kick; end
      if (slot_start == 8'h02 && t1 < 0) t1 = c;
    end
    chk(k0 == 4'h2, "R7 kick strobe", 32'(k0), 32'h2);
    chk(t0 >= 0 && t1 - t0 == 3 * TDIV, "R7 chained delay", t1 - t0, 3 * TDIV);
    rd(6'h10, r);
    chk(r == 32'h0200_0003, "R7 target stopped after run", r, 32'h0200_0003);
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);

    // R8 clear run bit stops periodic channel
    wr(6'h20, 32'h1014_0002);
    quiet(30, hits);
    chk(hits > 0, "R8 running before stop", hits, 1);
    wr(6'h28, 32'h0010_0000);
    quiet(60, hits);
    chk(hits == 0, "R8 no strobes after stop", hits, 0);
    rd(6'h20, r);
    chk(r == 32'h1004_0002, "R8 fields kept", r, 32'h1004_0002);
    wr(6'h20, 32'h0);

    // R9 zero write disables
    wr(6'h30, 32'h0418_0001);
    quiet(20, hits);
    chk(hits > 0, "R9 running before zero", hits, 1);
    wr(6'h30, 32'h0);
    quiet(60, hits);
    chk(hits == 0, "R9 no strobes after zero", hits, 0);
    rd(6'h30, r);
    chk(r == 32'h0, "R9 reads zero", r, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule